// File: doc/BRIEF.md
# Double-Buffered SPI Port

This block is a serial peripheral interface port on a 16-bit register bus. It works either as the clock-driving master or as a slave that follows an external clock. A single shift register moves the bits. A transmit holding buffer sits on one side of it and a receive holding buffer on the other, so software can queue the next word while the current one is still shifting, and can collect a finished word while the next one is arriving.

Software sees three addresses: control (0), status (1) and data (2). Writing the data address fills the transmit buffer. Reading the data address empties the receive buffer. In master mode the serial clock comes from the system clock through two cascaded dividers. Two pulse outputs report a finished transfer and a receive overflow.

Top module: `spi_dbuf`

## Requirements
- R1: Address 2 is the data port: a write stores the word in the transmit buffer and sets status bit 1 (tx full); a read returns the receive buffer and clears status bit 0 (rx full). Status bit 2 shows a master transfer in progress. After reset every register reads 0.
- R2: In master mode each half period of the serial clock lasts P*S system cycles, where control[1:0] picks P: 0→1, 1→4, 2→16, 3→64.
- R3: The second divider factor is S = control[4:2] + 1, so S ranges over 1..8.
- R4: control[5]=1 makes the port the master: it drives sck_o (sck_oe=1) and starts a transfer whenever the transmit buffer is full and no transfer is running. control[5]=0 makes it a slave clocked by sck_i.
- R5: control[10]=1 selects 16-bit transfers; otherwise a transfer moves the low 8 bits and the upper receive bits read 0. Bits leave and enter most significant first.
- R6: The serial clock idles low. With control[8]=0, data is launched on falling edges (the first bit before the first edge) and sampled on rising edges. With control[8]=1, data is launched on rising edges and sampled on falling edges.
- R7: With control[6]=1 a master samples each input bit one half period later than the normal sampling edge, which is at the end of that bit. A slave ignores this bit, and software keeps it 0 in slave mode.
- R8: irq_done is a one-cycle pulse in the cycle after every completed transfer. irq_err pulses in that same cycle when the transfer overflowed.
- R9: A transfer that completes while rx full is set is discarded. The receive buffer keeps its old word, and status bit 6 sets and stays set until a status write with bit 6 = 0; a status write with bit 6 = 1 leaves it unchanged.
- R10: control[7]=1 makes the active-low select ss_n_i gate a slave. Raising the select mid-transfer resets the bit count, with no completion. With control[7]=0 the select is ignored. Software sets control[7] whenever control[8] is set in slave mode.
- R11: Status bit 15 enables the port. While it is 0 the shift logic is held idle, sck_o stays low, sdo_oe is 0, and the buffers keep their contents. A queued word starts once the port is enabled.
- R12: A data write during a master transfer is held in the transmit buffer and is sent as the next transfer, right after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drains the receive buffer at address 2) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable (0 means released) |
| irq_done | output | 1 | Transfer-complete pulse |
| irq_err | output | 1 | Receive-overflow pulse |

## Verification
The bench builds the port with its default 16-bit word and 8-bit byte widths, so both transfer lengths and the full divider range are reachable. Divider settings from 1×1 to 64×8 are measured as clock periods on sck_o. A bench responder that changes its data right after each sampling edge makes the delayed-sample setting visible as a one-bit shift. Slave runs, driven with a slow external clock, cover the select gating, the aborted frame, and the released select.

// File: rtl/spi_dbuf.sv
module spi_dbuf #(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  input  logic          ss_n_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe,
  output logic          irq_done,
  output logic          irq_err
);
  localparam int CW = $clog2(2*DW+1);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] ctrl, txbuf, rxbuf, shreg;
  logic en, ovf, txfull, rxfull, busy, pend, dout, sck_q;
  logic [CW-1:0] ecnt, bcnt;
  logic [HW-1:0] pcnt, hp;
  logic [2:0] sck_sy;
  logic [1:0] ss_sy;

  wire [1:0] pri    = ctrl[1:0];
  wire [2:0] sec    = ctrl[4:2];
  wire       master = ctrl[5];
  wire       phase  = ctrl[6];
  wire       ssen   = ctrl[7];
  wire       ckedge = ctrl[8];
  wire       word   = ctrl[10];

  wire [CW-1:0] nb   = word ? CW'(DW) : CW'(BW);
  wire [CW-1:0] twon = nb << 1;
  wire [IW-1:0] msb  = word ? IW'(DW-1) : IW'(BW-1);
  wire [IW-1:0] msb2 = msb - 1'b1;

  assign hp = (pri == 2'd0 ? HW'(1) : pri == 2'd1 ? HW'(4) : pri == 2'd2 ? HW'(16) : HW'(64))
            * (HW'(sec) + HW'(1));

  wire tick    = busy && (pcnt == hp - 1'b1);
  wire in_clk  = ecnt < twon;
  wire is_cap  = in_clk && (ecnt[0] == ckedge);
  wire shift_m = tick && ((is_cap && !phase) || pend);
  wire fin_m   = tick && (((ecnt == twon - 1'b1) && !(is_cap && phase)) || (ecnt == twon));

  wire srise = sck_sy[1] & ~sck_sy[2];
  wire sfall = ~sck_sy[1] & sck_sy[2];
  wire sel   = !ssen || !ss_sy[1];
  wire scap  = en && !master && sel && (ckedge ? sfall : srise);
  wire slau  = en && !master && sel && (ckedge ? srise : sfall);
  wire fin_s = scap && (bcnt == nb - 1'b1);
  wire fin   = fin_m || fin_s;

  wire [DW-1:0] nxt    = {shreg[DW-2:0], sdi_i};
  wire [DW-1:0] full   = (fin_s || shift_m) ? nxt : shreg;
  wire [DW-1:0] finval = word ? full : {{(DW-BW){1'b0}}, full[BW-1:0]};

  wire wr_ctl  = bus_wr && bus_addr == 2'd0;
  wire wr_stat = bus_wr && bus_addr == 2'd1;
  wire wr_dat  = bus_wr && bus_addr == 2'd2;
  wire rd_dat  = bus_rd && bus_addr == 2'd2;
  wire rx_busy = rxfull && !rd_dat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; txbuf <= '0; rxbuf <= '0; shreg <= '0;
      en <= 1'b0; ovf <= 1'b0; txfull <= 1'b0; rxfull <= 1'b0;
      busy <= 1'b0; pend <= 1'b0; dout <= 1'b0; sck_q <= 1'b0;
      ecnt <= '0; bcnt <= '0; pcnt <= '0; sck_sy <= '0; ss_sy <= 2'b11;
      irq_done <= 1'b0; irq_err <= 1'b0;
    end else begin
      sck_sy   <= {sck_sy[1:0], sck_i};
      ss_sy    <= {ss_sy[0], ss_n_i};
      irq_done <= fin;
      irq_err  <= fin && rx_busy;

      if (!en) begin
        busy <= 1'b0; pend <= 1'b0; ecnt <= '0; pcnt <= '0; sck_q <= 1'b0; bcnt <= '0;
      end else if (master) begin
        if (!busy) begin
          if (txfull) begin
            shreg <= txbuf; dout <= txbuf[msb]; txfull <= 1'b0;
            busy <= 1'b1; ecnt <= '0; pcnt <= '0; pend <= 1'b0;
          end
        end else begin
          pcnt <= tick ? '0 : pcnt + 1'b1;
          if (tick) begin
            if (in_clk) begin
              sck_q <= ~sck_q;
              ecnt  <= ecnt + 1'b1;
            end
            if (shift_m) shreg <= nxt;
            pend <= is_cap && phase;
            if (in_clk && !is_cap) dout <= shift_m ? shreg[msb2] : shreg[msb];
            if (fin_m) busy <= 1'b0;
          end
        end
      end else begin
        if (!sel) bcnt <= '0;
        else if (scap) begin
          shreg <= nxt;
          bcnt  <= fin_s ? '0 : bcnt + 1'b1;
        end else if (slau) dout <= shreg[msb];
        if (bcnt == '0 && txfull && !scap) begin
          shreg <= txbuf; dout <= txbuf[msb]; txfull <= 1'b0;
        end
      end

      if (wr_ctl) ctrl <= bus_wdata & DW'(16'h05FF);
      if (wr_stat) begin
        en  <= bus_wdata[15];
        ovf <= ovf & bus_wdata[6];
      end
      if (wr_dat) begin
        txbuf <= bus_wdata; txfull <= 1'b1;
      end
      if (rd_dat) rxfull <= 1'b0;
      if (fin) begin
        if (rx_busy) ovf <= 1'b1;
        else begin
          rxbuf <= finval; rxfull <= 1'b1;
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign sck_oe = en && master;
  assign sdo_o  = dout;
  assign sdo_oe = en && (master || sel);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctrl;
      2'd1:    bus_rdata = {en, 8'b0, ovf, 3'b0, busy, txfull, rxfull};
      2'd2:    bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase
  end

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(wr_stat && !bus_wdata[6]) |=> ovf);
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> irq_done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
  a_r9_rx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $stable(rxbuf));
  a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sck_o && !busy);
endmodule

// File: tb/tb_spi_dbuf.sv
`timescale 1ns/100ps
module tb_spi_dbuf;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bus_wr, bus_rd, sck_i, ss_n_i, sdi_i;
  logic [1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic sck_o, sck_oe, sdo_o, sdo_oe, irq_done, irq_err;

  logic lb = 1'b0, resp_on = 1'b0, resp_edge = 1'b0, sdi_tb = 1'b0, prev_sck = 1'b0;
  logic [7:0] resp_sr = '0;
  int total = 0, bad = 0, ndone = 0, nerr = 0;
  bit finished = 0;

  assign sdi_i = lb ? sdo_o : (resp_on ? resp_sr[7] : sdi_tb);

  spi_dbuf dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .ss_n_i(ss_n_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .irq_done(irq_done), .irq_err(irq_err));

  always @(posedge clk) begin
    if (irq_done) ndone++;
    if (irq_err) nerr++;
  end

  always @(negedge clk) begin
    if (resp_on && sck_o != prev_sck && sck_o == !resp_edge) resp_sr <= {resp_sr[6:0], 1'b0};
    prev_sck <= sck_o;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = (a == 2'd2); #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] mk(int pri, int sec, bit ms, bit ph, bit ssen, bit edg, bit wd);
    return 16'(pri) | 16'(sec << 2) | 16'(ms) << 5 | 16'(ph) << 6 | 16'(ssen) << 7
         | 16'(edg) << 8 | 16'(wd) << 10;
  endfunction

  task automatic wait_done(int n0);
    for (int i = 0; i < 20000 && ndone <= n0; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 reset ctrl", v, 0);
    rd(2'd1, v); chk("R1 reset status", v, 0);
    rd(2'd2, v); chk("R1 reset data", v, 0);
    chk("R11 reset sdo_oe", sdo_oe, 0);
  endtask

  task automatic t_loop(string req, logic [15:0] c, logic [15:0] tx, logic [15:0] exp);
    logic [15:0] v; int n0;
    lb = 1'b1; resp_on = 1'b0;
    wr(2'd0, c); wr(2'd1, 16'h8000);
    n0 = ndone;
    wr(2'd2, tx);
    wait_done(n0);
    repeat (2) @(negedge clk);
    chk({req, " irq count"}, ndone, n0 + 1);
    rd(2'd2, v); chk({req, " rx"}, v, exp);
    rd(2'd1, v); chk({req, " rx drained"}, v[0], 0);
  endtask

  task automatic t_div(string req, int pri, int sec);
    logic [15:0] v; int n0, cyc;
    lb = 1'b1;
    wr(2'd0, mk(pri, sec, 1, 0, 0, 0, 0)); wr(2'd1, 16'h8000);
    n0 = ndone;
    wr(2'd2, 16'h0055);
    while (sck_o !== 1'b1) @(negedge clk);
    while (sck_o === 1'b1) @(negedge clk);
    cyc = 0;
    while (sck_o !== 1'b1) begin @(negedge clk); cyc++; end
    while (sck_o === 1'b1) begin @(negedge clk); cyc++; end
    chk(req, cyc, 2 * (pri == 0 ? 1 : pri == 1 ? 4 : pri == 2 ? 16 : 64) * (sec + 1));
    wait_done(n0);
    rd(2'd2, v);
  endtask

  task automatic t_phase(bit ph, bit edg, logic [7:0] pat, logic [7:0] exp);
    logic [15:0] v; int n0;
    lb = 1'b0; resp_on = 1'b1; resp_edge = edg;
    wr(2'd0, mk(0, 1, 1, ph, 0, edg, 0)); wr(2'd1, 16'h8000);
    @(negedge clk); resp_sr = pat;
    n0 = ndone;
    wr(2'd2, 16'h00F0);
    wait_done(n0);
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R7 sampled data", v, {8'h00, exp});
    chk("R6 sck idles low", sck_o, 0);
    resp_on = 1'b0;
  endtask

  task automatic t_overflow();
    logic [15:0] v; int n0, e0;
    lb = 1'b1;
    wr(2'd0, mk(0, 0, 1, 0, 0, 0, 0)); wr(2'd1, 16'h8000);
    n0 = ndone; e0 = nerr;
    wr(2'd2, 16'h0011); wait_done(n0);
    wr(2'd2, 16'h0022); wait_done(n0 + 1);
    repeat (2) @(negedge clk);
    chk("R8 err pulse", nerr, e0 + 1);
    rd(2'd1, v); chk("R9 overflow flag set", v[6], 1);
    rd(2'd2, v); chk("R9 old word kept", v, 16'h0011);
    wr(2'd1, 16'h8040);
    rd(2'd1, v); chk("R9 write 1 keeps flag", v[6], 1);
    wr(2'd1, 16'h8000);
    rd(2'd1, v); chk("R9 write 0 clears flag", v[6], 0);
  endtask

  task automatic t_dbuf();
    logic [15:0] v; int n0;
    lb = 1'b1;
    wr(2'd0, mk(1, 0, 1, 0, 0, 0, 0)); wr(2'd1, 16'h8000);
    n0 = ndone;
    wr(2'd2, 16'h005A);
    repeat (5) @(negedge clk);
    wr(2'd2, 16'h003C);
    rd(2'd1, v); chk("R12 queued while busy", v[2:1], 2'b11);
    wait_done(n0);
    rd(2'd2, v); chk("R12 first word", v, 16'h005A);
    rd(2'd1, v); chk("R12 next started", v[2:1], 2'b10);
    wait_done(n0 + 1);
    rd(2'd2, v); chk("R12 second word", v, 16'h003C);
  endtask

  task automatic sxfer(logic [7:0] mosi, int nb, output logic [7:0] miso);
    miso = '0;
    for (int i = 0; i < nb; i++) begin
      sdi_tb = mosi[7-i];
      repeat (8) @(negedge clk);
      miso[7-i] = sdo_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_slave();
    logic [15:0] v; logic [7:0] m; int n0;
    lb = 1'b0; resp_on = 1'b0;
    wr(2'd0, mk(0, 0, 0, 0, 1, 0, 0)); wr(2'd1, 16'h8000);
    wr(2'd2, 16'h00C6);
    n0 = ndone;
    ss_n_i = 1'b0; repeat (4) @(negedge clk);
    chk("R10 sdo driven when selected", sdo_oe, 1);
    sxfer(8'h9B, 8, m);
    chk("R4 slave done", ndone, n0 + 1);
    chk("R5 slave sent msb first", m, 8'hC6);
    rd(2'd2, v); chk("R4 slave rx", v, 16'h009B);
    wr(2'd2, 16'h00FF);
    n0 = ndone;
    sxfer(8'hE0, 3, m);
    ss_n_i = 1'b1; repeat (10) @(negedge clk);
    chk("R10 abort gives no irq", ndone, n0);
    chk("R10 sdo released when deselected", sdo_oe, 0);
    wr(2'd2, 16'h0081);
    ss_n_i = 1'b0; repeat (4) @(negedge clk);
    sxfer(8'h4D, 8, m);
    chk("R10 after abort rx", ndone, n0 + 1);
    rd(2'd2, v); chk("R10 count restarted", v, 16'h004D);
    chk("R10 after abort tx", m, 8'h81);
    ss_n_i = 1'b1;
    wr(2'd0, mk(0, 0, 0, 0, 0, 0, 0));
    n0 = ndone;
    wr(2'd2, 16'h0012);
    sxfer(8'h35, 8, m);
    chk("R10 select ignored when off", ndone, n0 + 1);
    rd(2'd2, v); chk("R10 ignored select rx", v, 16'h0035);
  endtask

  task automatic t_disable();
    logic [15:0] v; int n0, tog;
    lb = 1'b1;
    wr(2'd0, mk(0, 0, 1, 0, 0, 0, 0)); wr(2'd1, 16'h0000);
    n0 = ndone;
    wr(2'd2, 16'h0077);
    tog = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (sck_o) tog++; end
    chk("R11 no clock when off", tog, 0);
    chk("R11 sdo released when off", sdo_oe, 0);
    chk("R11 no transfer when off", ndone, n0);
    rd(2'd1, v); chk("R11 buffer kept", v[1], 1);
    wr(2'd1, 16'h8000);
    wait_done(n0);
    rd(2'd2, v); chk("R11 queued word sent", v, 16'h0077);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    sck_i = 0; ss_n_i = 1; sdi_tb = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loop("R4 byte edge0", mk(0, 0, 1, 0, 0, 0, 0), 16'h00A7, 16'h00A7);
    t_loop("R5 word", mk(0, 1, 1, 0, 0, 0, 1), 16'hA5C3, 16'hA5C3);
    t_loop("R5 byte drops upper", mk(0, 0, 1, 0, 0, 0, 0), 16'hBE3D, 16'h003D);
    t_loop("R6 edge1 word", mk(1, 0, 1, 0, 0, 1, 1), 16'h1E87, 16'h1E87);
    t_div("R2 div 1x1", 0, 0);
    t_div("R2 div 16x1", 2, 0);
    t_div("R3 div 4x3", 1, 2);
    t_div("R3 div 64x8", 3, 7);
    t_phase(0, 0, 8'hB4, 8'hB4);
    t_phase(1, 0, 8'hB4, 8'h68);
    t_phase(1, 1, 8'h93, 8'h26);
    t_overflow();
    t_dbuf();
    t_slave();
    t_disable();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule